// File: doc/BRIEF.md
# Three-Port Program Register File

This block holds the general-purpose program registers of a small processor core. Two read ports and one write port work in the same cycle, and each port has its own register identifier. A read port returns the selected register's contents combinationally, so a decode stage can fetch both source operands within one cycle. The write port commits on the rising clock edge. The storage array is addressed directly by the identifier.

Identifiers wide enough to exceed the register count leave a range of codes that select no register. When an instruction has no source or no destination, it presents one of these codes. A read port given such a code drives zero. A write given such a code is discarded. Because of this, the pipeline needs no separate read or write enable. There is no forwarding inside the block: a value written in a cycle becomes readable from the following cycle.

Top module: `regfile_3p`

## Requirements
- R1: When `rst` is sampled high on a rising edge, every register becomes zero. In the cycle after reset both read ports return zero for every identifier, and a write presented while `rst` is high is discarded.
- R2: A write with an identifier below `NUM_REGS` (0 to 7 by default) stores `wr_data` into that register on the rising edge. Any read of that register from the next cycle on returns the stored word.
- R3: Read data is combinational. A change of a read identifier between clock edges changes the read data within the same cycle.
- R4: Each read port delivers its own register's value independently of the other port. Both ports may also name the same register.
- R5: A read identifier in the range `NUM_REGS` to 2^`ID_W`-1 (8 to 15 by default) drives zero on that port's data output.
- R6: A write identifier in the range `NUM_REGS` to 2^`ID_W`-1 changes no register.
- R7: A read of the register being written in the same cycle returns the value the register held before that edge.
- R8: A write to one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset that clears all registers |
| rd_a_id | input | ID_W (4) | Register identifier for read port A; codes at or above NUM_REGS select nothing |
| rd_a_data | output | DATA_W (32) | Contents of the register selected by rd_a_id, or zero |
| rd_b_id | input | ID_W (4) | Register identifier for read port B |
| rd_b_data | output | DATA_W (32) | Contents of the register selected by rd_b_id, or zero |
| wr_id | input | ID_W (4) | Destination register identifier; codes at or above NUM_REGS discard the write |
| wr_data | input | DATA_W (32) | Word stored on the rising edge when wr_id selects a register |

## Verification
The bench instantiates the block with the default geometry of eight 32-bit registers and 4-bit identifiers, and overrides the read style to the one-hot AND-OR variant. With 4-bit identifiers, eight codes select no register. The bench drives every one of these null codes on both read ports and on the write port, so the whole null range is covered rather than only the single code just above the last register. With eight registers, every register can also be written, overwritten back to back, and read in the same cycle as its own write.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

   localparam int unsigned RF_DATA_W_DEF   = 32;
   localparam int unsigned RF_NUM_REGS_DEF = 8;
   localparam int unsigned RF_ID_W_DEF     = 4;

   // Read-path implementation variants
   typedef enum logic {
      RD_INDEXED = 1'b0,  // binary-indexed multiplexer
      RD_ONEHOT  = 1'b1   // one-hot select, AND-OR reduction
   } rd_style_e;

endpackage

// File: rtl/rf_id_decode.sv
// Splits a register identifier into a "selects a real register" flag and
// a raw one-hot vector over its low index bits.
module rf_id_decode #(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned NUM_REGS = 8
) (
   input  logic [ID_W-1:0]     id,
   output logic                hit,
   output logic [NUM_REGS-1:0] raw_onehot
);
   localparam int unsigned IDX_W = $clog2(NUM_REGS);
   localparam logic [ID_W-1:0] FIRST_NULL = ID_W'(NUM_REGS);

   logic [IDX_W-1:0] idx;

   assign idx = id[IDX_W-1:0];
   assign hit = (id < FIRST_NULL);

   always_comb begin
      for (int i = 0; i < NUM_REGS; i++) begin
         raw_onehot[i] = (idx == IDX_W'(i));
      end
   end
endmodule

// File: rtl/rf_storage.sv
// One flop word per register, each with its own write select.
module rf_storage #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_REGS-1:0] wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   q [NUM_REGS]
);
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst) begin
            q[r] <= '0;
         end else if (wr_sel[r]) begin
            q[r] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/rf_read_port.sv
// Combinational read port; a null identifier yields zero.
module rf_read_port
   import regfile_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_REGS   = 8,
   parameter int unsigned ID_W       = 4,
   parameter rd_style_e   READ_STYLE = RD_INDEXED
) (
   input  logic [ID_W-1:0]   id,
   input  logic [DATA_W-1:0] q [NUM_REGS],
   output logic [DATA_W-1:0] data
);
   localparam int unsigned IDX_W = $clog2(NUM_REGS);
   localparam logic [ID_W-1:0] FIRST_NULL = ID_W'(NUM_REGS);

   if (READ_STYLE == RD_ONEHOT) begin : g_onehot
      logic                hit;
      logic [NUM_REGS-1:0] raw_sel;
      logic [NUM_REGS-1:0] sel;

      rf_id_decode #(
         .ID_W     (ID_W),
         .NUM_REGS (NUM_REGS)
      ) u_dec (
         .id         (id),
         .hit        (hit),
         .raw_onehot (raw_sel)
      );

      assign sel = raw_sel & {NUM_REGS{hit}};

      always_comb begin
         data = '0;
         for (int i = 0; i < NUM_REGS; i++) begin
            data = data | (q[i] & {DATA_W{sel[i]}});
         end
      end
   end else begin : g_indexed
      logic [IDX_W-1:0] idx;
      logic             hit;

      assign idx  = id[IDX_W-1:0];
      assign hit  = (id < FIRST_NULL);
      assign data = hit ? q[idx] : '0;
   end
endmodule

// File: rtl/regfile_3p.sv
// Two combinational read ports, one edge-triggered write port, with
// identifier codes at or above NUM_REGS reserved as "no register".
module regfile_3p
   import regfile_pkg::*;
#(
   parameter int unsigned DATA_W     = RF_DATA_W_DEF,
   parameter int unsigned NUM_REGS   = RF_NUM_REGS_DEF,
   parameter int unsigned ID_W       = RF_ID_W_DEF,
   parameter rd_style_e   READ_STYLE = RD_INDEXED
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ID_W-1:0]   rd_a_id,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ID_W-1:0]   rd_b_id,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int unsigned ID_SPACE = 1 << ID_W;

   // Elaboration-time parameter checks
   if (NUM_REGS < 2) begin : g_chk_regs
      $error("regfile_3p: NUM_REGS must be at least 2");
   end
   if (NUM_REGS >= ID_SPACE) begin : g_chk_null
      $error("regfile_3p: ID_W leaves no code free for the null identifier");
   end
   if (DATA_W < 1) begin : g_chk_width
      $error("regfile_3p: DATA_W must be positive");
   end

   logic                wr_hit;
   logic [NUM_REGS-1:0] wr_raw;
   logic [NUM_REGS-1:0] wr_sel;
   logic [DATA_W-1:0]   regs_q [NUM_REGS];

   rf_id_decode #(
      .ID_W     (ID_W),
      .NUM_REGS (NUM_REGS)
   ) u_wr_dec (
      .id         (wr_id),
      .hit        (wr_hit),
      .raw_onehot (wr_raw)
   );

   assign wr_sel = wr_raw & {NUM_REGS{wr_hit}};

   rf_storage #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .q       (regs_q)
   );

   rf_read_port #(
      .DATA_W     (DATA_W),
      .NUM_REGS   (NUM_REGS),
      .ID_W       (ID_W),
      .READ_STYLE (READ_STYLE)
   ) u_rd_a (
      .id   (rd_a_id),
      .q    (regs_q),
      .data (rd_a_data)
   );

   rf_read_port #(
      .DATA_W     (DATA_W),
      .NUM_REGS   (NUM_REGS),
      .ID_W       (ID_W),
      .READ_STYLE (READ_STYLE)
   ) u_rd_b (
      .id   (rd_b_id),
      .q    (regs_q),
      .data (rd_b_data)
   );
endmodule

// File: rtl/regfile_3p_chk.sv
module regfile_3p_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned ID_W     = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [ID_W-1:0]   rd_a_id,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [ID_W-1:0]   rd_b_id,
   input logic [DATA_W-1:0] rd_b_data,
   input logic [ID_W-1:0]   wr_id,
   input logic [DATA_W-1:0] wr_data
);
   localparam logic [ID_W-1:0] FIRST_NULL = ID_W'(NUM_REGS);

   // R1: first cycle after a reset edge reads zero on both ports
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

   // R5: null read identifiers drive zero
   assert_null_read_a_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_a_id >= FIRST_NULL) |-> (rd_a_data == '0));
   assert_null_read_b_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_b_id >= FIRST_NULL) |-> (rd_b_data == '0));

   // R2: a committed write is visible on the next cycle
   assert_write_visible_a_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_id) < FIRST_NULL && rd_a_id == $past(wr_id))
      |-> (rd_a_data == $past(wr_data)));
   assert_write_visible_b_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_id) < FIRST_NULL && rd_b_id == $past(wr_id))
      |-> (rd_b_data == $past(wr_data)));

   // R6, R8: a register not targeted by the last write keeps its value
   assert_untouched_a_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && rd_a_id == $past(rd_a_id) && rd_a_id != $past(wr_id))
      |-> $stable(rd_a_data));
   assert_untouched_b_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && rd_b_id == $past(rd_b_id) && rd_b_id != $past(wr_id))
      |-> $stable(rd_b_data));
endmodule

bind regfile_3p regfile_3p_chk #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS),
   .ID_W     (ID_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rd_a_id   (rd_a_id),
   .rd_a_data (rd_a_data),
   .rd_b_id   (rd_b_id),
   .rd_b_data (rd_b_data),
   .wr_id     (wr_id),
   .wr_data   (wr_data)
);

// File: tb/test_regfile_3p.sv
module test_regfile_3p;
   import regfile_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int NR = 8;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [IW-1:0] rd_a_id = '0;
   logic [IW-1:0] rd_b_id = '0;
   logic [IW-1:0] wr_id = 4'd8;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_a_data;
   logic [DW-1:0] rd_b_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [DW-1:0] exp_a;
      logic [DW-1:0] exp_b;
      string         tag;
   } item_t;

   item_t         sb_q[$];
   logic [DW-1:0] model [NR];

   regfile_3p #(
      .DATA_W     (DW),
      .NUM_REGS   (NR),
      .ID_W       (IW),
      .READ_STYLE (RD_ONEHOT)
   ) i_regfile_3p (
      .clk       (clk),
      .rst       (rst),
      .rd_a_id   (rd_a_id),
      .rd_a_data (rd_a_data),
      .rd_b_id   (rd_b_id),
      .rd_b_data (rd_b_data),
      .wr_id     (wr_id),
      .wr_data   (wr_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] expect_rd(logic [IW-1:0] id);
      return (int'(id) < NR) ? model[id] : '0;
   endfunction

   function automatic logic [DW-1:0] pattern(int i);
      return 32'h1357_9BDF ^ (32'h0101_0101 * (i + 1)) ^ 32'(i << 28);
   endfunction

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // Driver: apply one cycle of stimulus, queue expected read values
   task automatic step(logic [IW-1:0] a, logic [IW-1:0] b,
                       logic [IW-1:0] w, logic [DW-1:0] wd, string tag);
      item_t it;
      @(negedge clk);
      rd_a_id = a;
      rd_b_id = b;
      wr_id   = w;
      wr_data = wd;
      it.exp_a = expect_rd(a);
      it.exp_b = expect_rd(b);
      it.tag   = tag;
      sb_q.push_back(it);
      if (int'(w) < NR && !rst) model[w] = wd;
   endtask

   task automatic read_all(string tag);
      for (int i = 0; i < NR; i++) begin
         step(IW'(i), IW'(NR - 1 - i), 4'd8, '0, tag);
      end
   endtask

   // Monitor: compare queued expectations after the inputs settle
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check({it.tag, " port A"}, rd_a_data, it.exp_a);
            check({it.tag, " port B"}, rd_b_data, it.exp_b);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      for (int i = 0; i < NR; i++) model[i] = '0;

      // R1: writes during reset are discarded
      step(4'd3, 4'd0, 4'd3, 32'hDEAD_BEEF, "R1 during reset");
      step(4'd3, 4'd3, 4'd3, 32'hDEAD_BEEF, "R1 during reset");
      @(negedge clk);
      wr_id = 4'd8;
      rst   = 1'b0;
      read_all("R1 after reset");

      // R2, R7: write every register while reading it in the same cycle
      for (int i = 0; i < NR; i++) begin
         step(IW'(i), IW'((i + 1) % NR), IW'(i), pattern(i), "R7 same-cycle read");
      end

      // R2, R4: independent readback on both ports
      for (int i = 0; i < NR; i++) begin
         step(IW'(i), IW'(i ^ 3), 4'd8, '0, "R2 R4 readback");
      end
      step(4'd5, 4'd5, 4'd8, '0, "R4 same register");

      // R5: every null code on both ports
      for (int i = NR; i < (1 << IW); i++) begin
         step(IW'(i), IW'(i - NR), 4'd8, '0, "R5 null read");
         step(IW'(i - NR), IW'(i), 4'd8, '0, "R5 null read");
      end

      // R6: every null code on the write port
      for (int i = NR; i < (1 << IW); i++) begin
         step(IW'(i - NR), IW'(i - NR), IW'(i), 32'hFFFF_FFFF, "R6 null write");
      end
      read_all("R6 contents kept");

      // R8: single write disturbs no neighbour
      step(4'd0, 4'd7, 4'd4, 32'hCAFE_F00D, "R8 write");
      read_all("R8 neighbours");

      // R2: back-to-back overwrite, latest wins
      step(4'd4, 4'd2, 4'd4, 32'h0BAD_CAFE, "R2 overwrite 1");
      step(4'd4, 4'd4, 4'd4, 32'h1234_5678, "R2 overwrite 2");
      step(4'd4, 4'd1, 4'd8, '0, "R2 latest value");

      // R3: combinational reads, identifier changed mid-cycle
      @(negedge clk);
      #(CLK_PERIOD/4 + 1);
      rd_a_id = 4'd2;
      #1 check("R3 comb port A reg2", rd_a_data, model[2]);
      rd_a_id = 4'd6;
      #1 check("R3 comb port A reg6", rd_a_data, model[6]);
      rd_b_id = 4'd9;
      #1 check("R3 comb port B null", rd_b_data, '0);
      rd_b_id = 4'd7;
      #1 check("R3 comb port B reg7", rd_b_data, model[7]);

      // R1: reset with non-zero contents
      @(negedge clk);
      rst   = 1'b1;
      wr_id = 4'd8;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NR; i++) model[i] = '0;
      read_all("R1 second reset");

      @(negedge clk);
      #(CLK_PERIOD/2);
      finish_up();
   end
endmodule